// File: doc/BRIEF.md
# Hook Supervision and Ring Trip

This block turns a synchronized loop-current comparator bit into a clean switch-hook indication for a subscriber line card. A phone that draws loop current is reported as off-hook: the active-low `shk_n` output goes low, and `led_n` always matches it. A change on the raw bit is accepted only when it has persisted for a set number of millisecond ticks. That window is short enough that dial-pulse breaks and makes still appear at `shk_n`.

The block also gates the ringing relay. A host asserts `ring_req` to ring the line, and the block drives `ring_drive` one clock later. While ringing is on, ringing current can look like loop current. During ringing an off-hook therefore has to persist for a longer window. Each switch of the relay, on or off, also opens a blanking window in which the raw bit is ignored. Once an off-hook is confirmed while ringing is requested, the block drops the relay drive by itself (ring trip). The drive stays off until the host withdraws the request.

All windows are counted in pulses of `tick_ms`, which is one clock wide and nominally 1 kHz. The interfaces are plain level pins. No data stream crosses the block, so there is no handshake and no back-pressure.

Top module: `hook_ring_trip`

## Requirements
- R1: While `rst_n` is low and after its release, `shk_n` and `led_n` are 1 and `ring_drive` is 0.
- R2: With no ringing or blanking active and `shk_n` high, `shk_n` goes low (off-hook) at the clock edge that samples the DEB_MS-th tick during which `loop_raw` has stayed 1 (1 = current present). A shorter run of 1s leaves `shk_n` high, and any return to 0 restarts the count.
- R3: With `shk_n` low, `shk_n` returns high at the edge that samples the DEB_MS-th tick of `loop_raw` continuously 0. This holds whether or not ringing is active.
- R4: `led_n` equals `shk_n` in every cycle.
- R5: With the line on-hook and no trip latched, `ring_drive` equals the value `ring_req` had at the previous clock edge. `ring_drive` is never 1 in the cycle after `ring_req` is sampled 0.
- R6: While `ring_drive` is 1 or blanking is active, going off-hook needs RING_QUAL_MS ticks of continuous `loop_raw` = 1, counted after blanking ends.
- R7: Each change of `ring_drive` starts a blanking window of BLANK_MS ticks. The window begins at the same edge as the change. During it `loop_raw` is ignored, any partial count is cleared, and `shk_n` does not change.
- R8: If `shk_n` is low while `ring_req` is 1, `ring_drive` is 0 from the next edge on. The trip stays latched, even after a later on-hook, until `ring_req` is sampled 0. The next request then drives the relay again.
- R9: If `ring_req` is asserted while the line is already off-hook, `ring_drive` stays 0.
- R10: `shk_n` changes only at an edge where `tick_ms` is sampled 1. The raw bit alone, without ticks, never moves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-clock pulse per millisecond |
| loop_raw | input | 1 | Synchronized loop-current comparator, 1 = current present |
| ring_req | input | 1 | Host request to ring, active high |
| shk_n | output | 1 | Debounced switch-hook, 0 = off-hook |
| led_n | output | 1 | LED drive, same value as `shk_n` |
| ring_drive | output | 1 | Ringing relay driver, 1 = energised |

## Verification
The embedded properties watch, on every cycle, the following rules:
- the hook state never moves without a tick or during blanking;
- every relay change opens blanking;
- the drive falls after an off-hook seen under a ringing request;
- a latched trip persists while the request is held.

Only the bench can show the exact qualification lengths: the tick on which the hook state flips outside ringing, with blanking, and under the longer ringing window. It sweeps the duration of a raw pulse across each threshold. It also shows that an answered line re-arms only after the request has been withdrawn and reasserted.

// File: rtl/hrt_pkg.sv
package hrt_pkg;

  typedef enum logic {
    HOOK_ON  = 1'b0,
    HOOK_OFF = 1'b1
  } hook_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hrt_debounce.sv
module hrt_debounce
  import hrt_pkg::*;
#(
  parameter int unsigned DEB_MS       = 20,
  parameter int unsigned RING_QUAL_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic loop_raw,
  input  logic blank,
  input  logic long_qual,
  output logic hook_off
);

  localparam int unsigned MAXL = max2(DEB_MS, RING_QUAL_MS);
  localparam int unsigned CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] DEB_M1  = CW'(DEB_MS - 1);
  localparam logic [CW-1:0] QUAL_M1 = CW'(RING_QUAL_MS - 1);

  hook_e         state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;
  logic          differs;

  assign differs = (hook_e'(loop_raw) != state_q);
  // Long window applies only when heading off-hook under ringing.
  assign lim_m1  = (loop_raw && long_qual) ? QUAL_M1 : DEB_M1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HOOK_ON;
      cnt_q   <= '0;
    end else if (blank || !differs) begin
      cnt_q <= '0;
    end else if (tick_ms) begin
      if (cnt_q >= lim_m1) begin
        state_q <= hook_e'(loop_raw);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hook_off = (state_q == HOOK_OFF);

  // R10: the hook state moves only on a sampled tick
  a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ms |=> $stable(state_q));

  // R7: blanking freezes the hook state
  a_r7_blank_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> $stable(state_q));

  // R2: counter stays inside the longest window
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXL));

endmodule

// File: rtl/hrt_ring_ctrl.sv
module hrt_ring_ctrl #(
  parameter int unsigned BLANK_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic ring_req,
  input  logic hook_off,
  output logic ring_drive,
  output logic blank,
  output logic ring_mode
);

  localparam int unsigned BW = $clog2(BLANK_MS + 1);
  localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_MS);

  logic          trip_q;
  logic          drive_q;
  logic [BW-1:0] blank_q;
  logic          trip_nxt;
  logic          drive_nxt;

  assign trip_nxt  = ring_req & (trip_q | hook_off);
  assign drive_nxt = ring_req & ~trip_q & ~hook_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q  <= 1'b0;
      drive_q <= 1'b0;
      blank_q <= '0;
    end else begin
      trip_q  <= trip_nxt;
      drive_q <= drive_nxt;
      if (drive_nxt != drive_q) begin
        blank_q <= BLANK_LD;
      end else if (tick_ms && (blank_q != '0)) begin
        blank_q <= blank_q - 1'b1;
      end
    end
  end

  assign ring_drive = drive_q;
  assign blank      = (blank_q != '0);
  assign ring_mode  = drive_q | blank;

  // R8: confirmed off-hook under a request cuts the relay
  a_r8_trip_cuts: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_req && hook_off) |=> !ring_drive);

  // R8: trip persists while the request is held
  a_r8_trip_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && ring_req) |=> (trip_q && !ring_drive));

  // R5: no drive without a request on the previous edge
  a_r5_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_req |=> !ring_drive);

  // R7: every relay change opens blanking
  a_r7_blank_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_drive != $past(ring_drive)) |-> blank);

endmodule

// File: rtl/hook_ring_trip.sv
module hook_ring_trip #(
  parameter int unsigned DEB_MS       = 20,
  parameter int unsigned RING_QUAL_MS = 100,
  parameter int unsigned BLANK_MS     = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic loop_raw,
  input  logic ring_req,
  output logic shk_n,
  output logic led_n,
  output logic ring_drive
);

  logic hook_off;
  logic blank;
  logic ring_mode;

  hrt_debounce #(
    .DEB_MS       (DEB_MS),
    .RING_QUAL_MS (RING_QUAL_MS)
  ) u_deb (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_ms   (tick_ms),
    .loop_raw  (loop_raw),
    .blank     (blank),
    .long_qual (ring_mode),
    .hook_off  (hook_off)
  );

  hrt_ring_ctrl #(
    .BLANK_MS (BLANK_MS)
  ) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_ms    (tick_ms),
    .ring_req   (ring_req),
    .hook_off   (hook_off),
    .ring_drive (ring_drive),
    .blank      (blank),
    .ring_mode  (ring_mode)
  );

  assign shk_n = ~hook_off;
  assign led_n = ~hook_off;

  // R9: a line already off-hook never sees the relay energise
  a_r9_no_ring_offhook: assert property (@(posedge clk) disable iff (!rst_n)
    (!shk_n && !ring_drive) |=> !ring_drive);

endmodule

// File: tb/hook_ring_trip_bench.sv
`timescale 1ns/1ps
module hook_ring_trip_bench;

  localparam int unsigned DEB   = 3;
  localparam int unsigned QUAL  = 6;
  localparam int unsigned BLANK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic loop_raw = 1'b0;
  logic ring_req = 1'b0;
  logic shk_n, led_n, ring_drive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hook_ring_trip #(
    .DEB_MS (DEB), .RING_QUAL_MS (QUAL), .BLANK_MS (BLANK)
  ) u_hook_ring_trip (
    .clk (clk), .rst_n (rst_n), .tick_ms (tick_ms), .loop_raw (loop_raw),
    .ring_req (ring_req), .shk_n (shk_n), .led_n (led_n), .ring_drive (ring_drive)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic led_chk();
    chk("R4 led", led_n, shk_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 shk", shk_n, 1'b1);
    chk("R1 led", led_n, 1'b1);
    chk("R1 drive", ring_drive, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 shk after release", shk_n, 1'b1);

    // R2: sweep pulse length around the plain window
    for (int len = 1; len <= DEB + 1; len++) begin
      loop_raw = 1'b1;
      ticks(len);
      chk("R2 off-hook window", shk_n, (len >= DEB) ? 1'b0 : 1'b1);
      led_chk();
      loop_raw = 1'b0;
      ticks(DEB + 1);
      chk("R3 recovered", shk_n, 1'b1);
    end

    // R3: on-hook threshold
    loop_raw = 1'b1;
    ticks(DEB);
    chk("R2 off", shk_n, 1'b0);
    loop_raw = 1'b0;
    ticks(DEB - 1);
    chk("R3 before window", shk_n, 1'b0);
    led_chk();
    ticks(1);
    chk("R3 at window", shk_n, 1'b1);

    // R10: no ticks, no change
    loop_raw = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 no tick", shk_n, 1'b1);
    loop_raw = 1'b0;
    @(negedge clk);

    // R5: drive follows request
    ring_req = 1'b1;
    @(negedge clk);
    chk("R5 drive on", ring_drive, 1'b1);
    ring_req = 1'b0;
    @(negedge clk);
    chk("R5 drive off", ring_drive, 1'b0);
    ticks(BLANK + 1);

    // R6/R7: sweep off-hook length while ringing
    for (int len = 1; len <= int'(BLANK + QUAL); len++) begin
      ring_req = 1'b1;
      @(negedge clk);
      chk("R5 ring start", ring_drive, 1'b1);
      loop_raw = 1'b1;
      ticks(len);
      chk("R6 ring window", shk_n, (len >= int'(BLANK + QUAL)) ? 1'b0 : 1'b1);
      if (len >= int'(BLANK + QUAL)) begin
        @(negedge clk);
        chk("R8 trip drops drive", ring_drive, 1'b0);
      end else begin
        chk("R6 drive held", ring_drive, 1'b1);
      end
      loop_raw = 1'b0;
      ring_req = 1'b0;
      ticks(BLANK + DEB + 2);
      chk("R3 ring recovered", shk_n, 1'b1);
    end

    // R7/R8: blanking after trip, latch, re-arm
    ring_req = 1'b1;
    @(negedge clk);
    loop_raw = 1'b1;
    ticks(BLANK + QUAL);
    @(negedge clk);
    chk("R8 tripped", ring_drive, 1'b0);
    loop_raw = 1'b0;
    ticks(BLANK + DEB - 1);
    chk("R7 blank after trip", shk_n, 1'b0);
    ticks(1);
    chk("R7 on-hook after blank", shk_n, 1'b1);
    led_chk();
    ticks(4);
    chk("R8 latch holds", ring_drive, 1'b0);
    ring_req = 1'b0;
    @(negedge clk);
    ring_req = 1'b1;
    @(negedge clk);
    chk("R8 re-arm", ring_drive, 1'b1);
    ring_req = 1'b0;
    ticks(BLANK + 1);

    // R9: request while already off-hook
    loop_raw = 1'b1;
    ticks(DEB);
    chk("R2 off before ring", shk_n, 1'b0);
    ring_req = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 no drive", ring_drive, 1'b0);
    ticks(3);
    chk("R9 still no drive", ring_drive, 1'b0);
    ring_req = 1'b0;
    loop_raw = 1'b0;
    ticks(DEB + 1);
    chk("R3 final", shk_n, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule